// File: doc/BRIEF.md
# Timed Match and Score Controller

This block runs one timed two-player match around a separate game engine. A start key opens a match. Both scores clear, the countdown loads the match length (90 seconds by default) and the play-enable output rises, which tells the game engine that moves are allowed. While play is enabled, a goal pulse from side A or side B adds one point to that side's two-digit BCD score. A one-cycle seconds pulse, made elsewhere, counts the remaining time down as two BCD digits.

When the last second expires, play-enable drops and the scores freeze. A three-bit one-hot result code then shows whether A won, B won or the match was drawn. The result stays up until the start key is pressed again, and that press begins a new match. Display scanning and any celebration effects belong to other blocks.

The controller is a three-state machine. IDLE is entered on reset. It leaves on an accepted start (transition IDLE->PLAY). PLAY leaves when the seconds pulse takes the timer from 01 to 00 (transition PLAY->OVER). OVER leaves on an accepted start (transition OVER->PLAY). A start while in PLAY is not accepted, so PLAY has no exit on start. Reset takes any state to IDLE.

Top module: `match_ctrl`

## Requirements
- R1: A synchronous reset puts the block in IDLE. In IDLE, play_en is 0, both scores read 00, the timer reads 90 and result is 000, and seconds pulses and goal pulses change nothing.
- R2: A start_key pulse in IDLE or OVER gives, one cycle later, play_en = 1, both scores 00, the timer at the match length (90) and result 000. A seconds pulse in that same cycle does not decrement the timer.
- R3: A start_key pulse while in PLAY is ignored: the timer, the scores and play_en keep their values.
- R4: In PLAY, each sec_tick lowers the timer by one in BCD. Units 0 borrows from the tens and becomes 9, so 90 goes to 89. Without sec_tick the timer holds.
- R5: The sec_tick that takes the timer from 01 to 00 also drops play_en on the same clock edge (PLAY->OVER). In OVER the timer stays at 00 whatever sec_tick does.
- R6: In PLAY, a goal_a or goal_b pulse adds exactly one point to that side's BCD score, and units 9 carries into the tens (09 goes to 10). Goals from both sides in one cycle both count, and this includes the cycle of the final seconds pulse.
- R7: A score of 99 saturates: a further goal leaves it at 99.
- R8: Goal pulses outside PLAY (in IDLE or OVER) are ignored, and the scores keep their values.
- R9: In OVER, result is one-hot with bit 0 = A wins, bit 1 = B wins and bit 2 = draw. The winner is found by comparing the tens digits first and the units digits only if the tens are equal. The result holds until the next accepted start, and it is 000 in IDLE and PLAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_key | input | 1 | One-cycle start pulse |
| sec_tick | input | 1 | One-cycle pulse once per second |
| goal_a | input | 1 | Goal pulse for side A |
| goal_b | input | 1 | Goal pulse for side B |
| score_a_tens | output | 4 | Side A score, tens digit (BCD) |
| score_a_units | output | 4 | Side A score, units digit (BCD) |
| score_b_tens | output | 4 | Side B score, tens digit (BCD) |
| score_b_units | output | 4 | Side B score, units digit (BCD) |
| time_tens | output | 4 | Remaining seconds, tens digit (BCD) |
| time_units | output | 4 | Remaining seconds, units digit (BCD) |
| play_en | output | 1 | High while a match is in progress |
| result | output | 3 | One-hot outcome: bit0 A wins, bit1 B wins, bit2 draw |

## Verification
The bench builds the block with its default match length, MATCH_SECONDS = 90. The seconds pulse is a plain input, so a full 90-second match takes about a hundred clock cycles. That keeps several complete matches within reach: the 90-to-89 borrow, the final 01-to-00 step and a draw, a tens-decided win and a units-decided win. A hundred goal pulses are likewise enough to push a score to 99 and test saturation.

// File: rtl/match_pkg.sv
package match_pkg;
    localparam int DIGIT_W = 4;
    localparam int RES_W   = 3;
    localparam int RES_A    = 0;
    localparam int RES_B    = 1;
    localparam int RES_DRAW = 2;
    localparam int SIDES    = 2;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } bcd2_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAY = 2'd1,
        ST_OVER = 2'd2
    } match_state_t;
endpackage

// File: rtl/match_fsm.sv
module match_fsm
    import match_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_key,
    input  logic         last_tick,
    output match_state_t state,
    output logic         load,
    output logic         play_en,
    output logic         judge_en
);
    match_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_key) state_d = ST_PLAY;
            ST_PLAY: if (last_tick) state_d = ST_OVER;
            ST_OVER: if (start_key) state_d = ST_PLAY;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        load     = 1'b0;
        play_en  = 1'b0;
        judge_en = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start_key;
            ST_PLAY: play_en = 1'b1;
            ST_OVER: begin
                judge_en = 1'b1;
                load     = start_key;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
    import match_pkg::*;
#(
    parameter int MATCH_SECONDS = 90
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  run,
    input  logic  sec_tick,
    output bcd2_t remain,
    output logic  last_tick
);
    localparam bcd_t LOAD_TENS  = bcd_t'(MATCH_SECONDS / 10);
    localparam bcd_t LOAD_UNITS = bcd_t'(MATCH_SECONDS % 10);

    bcd2_t cnt_q;
    logic  at_zero;
    logic  at_one;

    assign at_zero   = (cnt_q.tens == '0) && (cnt_q.units == '0);
    assign at_one    = (cnt_q.tens == '0) && (cnt_q.units == bcd_t'(1));
    assign last_tick = run && sec_tick && at_one;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q.tens  <= LOAD_TENS;
            cnt_q.units <= LOAD_UNITS;
        end else if (run && sec_tick && !at_zero) begin
            if (cnt_q.units == '0) begin
                cnt_q.units <= bcd_t'(9);
                cnt_q.tens  <= cnt_q.tens - bcd_t'(1);
            end else begin
                cnt_q.units <= cnt_q.units - bcd_t'(1);
            end
        end
    end

    assign remain = cnt_q;
endmodule

// File: rtl/score_keeper.sv
module score_keeper
    import match_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  enable,
    input  logic  goal,
    output bcd2_t score
);
    bcd2_t cnt_q;
    logic  full;

    assign full = (cnt_q.tens == bcd_t'(9)) && (cnt_q.units == bcd_t'(9));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (enable && goal && !full) begin
            if (cnt_q.units == bcd_t'(9)) begin
                cnt_q.units <= '0;
                cnt_q.tens  <= cnt_q.tens + bcd_t'(1);
            end else begin
                cnt_q.units <= cnt_q.units + bcd_t'(1);
            end
        end
    end

    assign score = cnt_q;
endmodule

// File: rtl/result_judge.sv
module result_judge
    import match_pkg::*;
(
    input  logic             valid,
    input  bcd2_t            score_a,
    input  bcd2_t            score_b,
    output logic [RES_W-1:0] result
);
    logic a_ahead;
    logic b_ahead;

    always_comb begin
        if (score_a.tens != score_b.tens) begin
            a_ahead = score_a.tens > score_b.tens;
            b_ahead = score_b.tens > score_a.tens;
        end else begin
            a_ahead = score_a.units > score_b.units;
            b_ahead = score_b.units > score_a.units;
        end
    end

    always_comb begin
        result = '0;
        if (valid) begin
            if (a_ahead)      result[RES_A]    = 1'b1;
            else if (b_ahead) result[RES_B]    = 1'b1;
            else              result[RES_DRAW] = 1'b1;
        end
    end
endmodule

// File: rtl/match_ctrl.sv
module match_ctrl
    import match_pkg::*;
#(
    parameter int MATCH_SECONDS = 90
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_key,
    input  logic             sec_tick,
    input  logic             goal_a,
    input  logic             goal_b,
    output logic [DIGIT_W-1:0] score_a_tens,
    output logic [DIGIT_W-1:0] score_a_units,
    output logic [DIGIT_W-1:0] score_b_tens,
    output logic [DIGIT_W-1:0] score_b_units,
    output logic [DIGIT_W-1:0] time_tens,
    output logic [DIGIT_W-1:0] time_units,
    output logic             play_en,
    output logic [RES_W-1:0] result
);
    match_state_t state;
    logic         load;
    logic         judge_en;
    logic         last_tick;
    bcd2_t        remain;
    bcd2_t        scores [SIDES];
    logic [SIDES-1:0] goals;

    assign goals = {goal_b, goal_a};

    match_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_key (start_key),
        .last_tick (last_tick),
        .state     (state),
        .load      (load),
        .play_en   (play_en),
        .judge_en  (judge_en)
    );

    countdown_timer #(.MATCH_SECONDS(MATCH_SECONDS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .run       (state == ST_PLAY),
        .sec_tick  (sec_tick),
        .remain    (remain),
        .last_tick (last_tick)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        score_keeper u_score (
            .clk    (clk),
            .rst    (rst),
            .clear  (load),
            .enable (play_en),
            .goal   (goals[s]),
            .score  (scores[s])
        );
    end

    result_judge u_judge (
        .valid   (judge_en),
        .score_a (scores[0]),
        .score_b (scores[1]),
        .result  (result)
    );

    assign score_a_tens  = scores[0].tens;
    assign score_a_units = scores[0].units;
    assign score_b_tens  = scores[1].tens;
    assign score_b_units = scores[1].units;
    assign time_tens     = remain.tens;
    assign time_units    = remain.units;
endmodule

// File: rtl/match_ctrl_chk.sv
module match_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_key,
    input logic       sec_tick,
    input logic       goal_a,
    input logic       goal_b,
    input logic [3:0] score_a_tens,
    input logic [3:0] score_a_units,
    input logic [3:0] score_b_tens,
    input logic [3:0] score_b_units,
    input logic [3:0] time_tens,
    input logic [3:0] time_units,
    input logic       play_en,
    input logic [2:0] result
);
    logic [7:0] sa, sb, tm;
    assign sa = {score_a_tens, score_a_units};
    assign sb = {score_b_tens, score_b_units};
    assign tm = {time_tens, time_units};

    AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(result)); // R9
    AST_NO_RESULT_IN_PLAY: assert property (@(posedge clk) disable iff (rst) play_en |-> result == 3'b000); // R9
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (start_key && !play_en) |=> (play_en && tm == 8'h90 && sa == 8'h00 && sb == 8'h00)); // R2
    AST_START_IGNORED_IN_PLAY: assert property (@(posedge clk) disable iff (rst)
        (start_key && play_en && !sec_tick && !goal_a && !goal_b) |=> ($stable(tm) && $stable(sa) && $stable(sb))); // R3
    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (play_en && !sec_tick) |=> $stable(tm)); // R4
    AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($fell(play_en) && !$past(rst)) |-> (tm == 8'h00 && result != 3'b000)); // R5
    AST_SCORE_SAT_A: assert property (@(posedge clk) disable iff (rst)
        (play_en && sa == 8'h99) |=> sa == 8'h99); // R7
    AST_NO_GOAL_OFFPLAY: assert property (@(posedge clk) disable iff (rst)
        (!play_en && !start_key) |=> ($stable(sa) && $stable(sb))); // R8
    AST_BCD_UNITS: assert property (@(posedge clk) disable iff (rst)
        (score_a_units <= 4'd9 && score_b_units <= 4'd9 && time_units <= 4'd9)); // R6
endmodule

bind match_ctrl match_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_key     (start_key),
    .sec_tick      (sec_tick),
    .goal_a        (goal_a),
    .goal_b        (goal_b),
    .score_a_tens  (score_a_tens),
    .score_a_units (score_a_units),
    .score_b_tens  (score_b_tens),
    .score_b_units (score_b_units),
    .time_tens     (time_tens),
    .time_units    (time_units),
    .play_en       (play_en),
    .result        (result)
);

// File: tb/tb_match_ctrl.sv
module tb_match_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, start_key, sec_tick, goal_a, goal_b;
    logic [3:0] score_a_tens, score_a_units, score_b_tens, score_b_units;
    logic [3:0] time_tens, time_units;
    logic       play_en;
    logic [2:0] result;

    int total = 0;
    int bad   = 0;

    match_ctrl dut (
        .clk(clk), .rst(rst), .start_key(start_key), .sec_tick(sec_tick),
        .goal_a(goal_a), .goal_b(goal_b),
        .score_a_tens(score_a_tens), .score_a_units(score_a_units),
        .score_b_tens(score_b_tens), .score_b_units(score_b_units),
        .time_tens(time_tens), .time_units(time_units),
        .play_en(play_en), .result(result)
    );

    function automatic int sa();  return score_a_tens * 10 + score_a_units; endfunction
    function automatic int sb();  return score_b_tens * 10 + score_b_units; endfunction
    function automatic int tv();  return time_tens * 10 + time_units;       endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: inputs applied, edge, then settle away from the edge
    task automatic cyc(input logic st, input logic tk, input logic ga, input logic gb);
        start_key = st; sec_tick = tk; goal_a = ga; goal_b = gb;
        @(posedge clk); #1;
        start_key = 0; sec_tick = 0; goal_a = 0; goal_b = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 play_en", play_en, 0);
        chk("R1 time", tv(), 90);
        chk("R1 score_a", sa(), 0);
        chk("R1 score_b", sb(), 0);
        chk("R1 result", result, 0);
    endtask

    task automatic t_idle_ignore();
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1);
        chk("R1 idle time", tv(), 90);
        chk("R8 idle score_a", sa(), 0);
        chk("R8 idle score_b", sb(), 0);
    endtask

    task automatic t_start();
        cyc(1, 1, 0, 0);
        chk("R2 play_en", play_en, 1);
        chk("R2 time no decrement on load", tv(), 90);
    endtask

    task automatic t_countdown();
        cyc(0, 1, 0, 0);
        chk("R4 borrow 90->89", tv(), 89);
        cyc(0, 0, 0, 0);
        chk("R4 hold", tv(), 89);
        for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0);
        chk("R4 80", tv(), 80);
    endtask

    task automatic t_goals();
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
        chk("R6 a=3", sa(), 3);
        cyc(0, 0, 1, 1);
        chk("R6 both a", sa(), 4);
        chk("R6 both b", sb(), 1);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
        chk("R6 carry a=10", sa(), 10);
    endtask

    task automatic t_start_in_play();
        cyc(1, 0, 0, 0);
        chk("R3 time", tv(), 80);
        chk("R3 score_a", sa(), 10);
        chk("R3 play_en", play_en, 1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 89; i++) cyc(0, 0, 1, 0);
        chk("R7 a=99", sa(), 99);
        cyc(0, 0, 1, 0);
        chk("R7 saturated", sa(), 99);
        chk("R7 b untouched", sb(), 1);
    endtask

    task automatic t_finish();
        for (int i = 0; i < 79; i++) cyc(0, 1, 0, 0);
        chk("R5 time 01", tv(), 1);
        chk("R5 still playing", play_en, 1);
        cyc(0, 1, 0, 1);
        chk("R5 play_en drops", play_en, 0);
        chk("R5 time 00", tv(), 0);
        chk("R6 last-cycle goal counts", sb(), 2);
        chk("R9 A wins", result, 1);
    endtask

    task automatic t_over_hold();
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1);
        chk("R5 over time", tv(), 0);
        chk("R8 over score_a", sa(), 99);
        chk("R8 over score_b", sb(), 2);
        chk("R9 result held", result, 1);
    endtask

    task automatic t_match(input int na, input int nb, input int exp_res, input string tag);
        cyc(1, 0, 0, 0);
        chk("R2 restart score_a", sa(), 0);
        chk("R2 restart score_b", sb(), 0);
        chk("R2 restart time", tv(), 90);
        chk("R9 cleared in play", result, 0);
        for (int i = 0; i < na; i++) cyc(0, 0, 1, 0);
        for (int i = 0; i < nb; i++) cyc(0, 0, 0, 1);
        for (int i = 0; i < 90; i++) cyc(0, 1, 0, 0);
        chk(tag, result, exp_res);
        chk("R5 over", play_en, 0);
    endtask

    task automatic t_reset_mid();
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
        do_reset();
        chk("R1 mid reset play_en", play_en, 0);
        chk("R1 mid reset time", tv(), 90);
        chk("R1 mid reset score_a", sa(), 0);
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; start_key = 0; sec_tick = 0; goal_a = 0; goal_b = 0;
        t_reset();
        t_idle_ignore();
        t_start();
        t_countdown();
        t_goals();
        t_start_in_play();
        t_saturate();
        t_finish();
        t_over_hold();
        t_match(12, 12, 4, "R9 draw");
        t_match(9, 10, 2, "R9 B wins on tens");
        t_match(21, 20, 1, "R9 A wins on units");
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule